// File: doc/BRIEF.md
# PCI Target with Load-Gated Configuration Retry

This block is a simplified 32-bit PCI target. It claims single-data-phase configuration and memory cycles. Configuration cycles reach a small configuration register store. Memory writes into a fixed address window go through a request/ready handshake into a byte-wide flash write buffer, and the target holds TRDY# high until the buffer has taken the byte. Memory reads in the window complete with zero data.

A level input reports whether the device's nonvolatile-memory autoload has finished. While that input is low, every configuration cycle that selects the target is answered with a Retry termination. The target records no address or command from a retried cycle, so a master may come back with any cycle it likes. Memory cycles are never gated by the autoload, and once the autoload is done every access is accepted.

Top module: `pcit_target`

## Requirements
- R1: While reset is high, and in the clock after it is sampled high, TRDY#, DEVSEL# and STOP# are high, ad_oe is low and wr_req is low.
- R2: For a claimed cycle, DEVSEL# goes low in the cycle that begins at the second rising edge counting from the edge that samples FRAME# low in the address phase.
- R3: DEVSEL# stays high for cycles that are not claimed. Claimed cycles are configuration read (C/BE# 1010) or write (1011) with idsel high and AD[1:0]=00, and memory read (0110) or write (0111) with AD[31:WIN_BITS] equal to MEM_BASE[31:WIN_BITS]. Every other command or address is not claimed.
- R4: If load_done is low on the edge where DEVSEL# is asserted, a claimed configuration cycle gets Retry. DEVSEL# and STOP# go low together with TRDY# held high. Both are released in the cycle after the first edge that samples FRAME# and IRDY# both high.
- R5: A retried configuration write leaves the configuration store unchanged.
- R6: A configuration write stores each byte lane i (AD[8i+7:8i]) whose active-low byte enable C/BE#[i] is 0, at word index AD[2+:log2(CFG_WORDS)]. A configuration read returns the stored word on ad_out, with ad_oe high, in the cycle where TRDY# is low.
- R7: A memory write in the window with exactly one byte enable low raises wr_req on the edge after IRDY# is sampled low. wr_data is the enabled lane's byte and wr_addr is {AD[WIN_BITS-1:2], lane}. All three hold steady until wr_ready is sampled high.
- R8: On the edge that samples wr_req and wr_ready both high, wr_req drops and TRDY# goes low.
- R9: A windowed memory write with zero, two, three or four byte enables low completes with TRDY# low on the edge after IRDY# is sampled low, and wr_req is never raised.
- R10: Memory cycles are claimed whatever the level of load_done. A memory read returns 32'h0 on ad_out with ad_oe high while TRDY# is low.
- R11: On the edge that samples IRDY# and TRDY# both low, TRDY#, DEVSEL# and ad_oe are released. A new FRAME# is accepted from the second edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Cycle frame from the initiator, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| idsel | input | 1 | Configuration select for this device |
| ad_in | input | 32 | Address/data bus as seen by the target |
| cbe_n | input | 4 | Command in the address phase, active-low byte enables in the data phase |
| ad_out | output | 32 | Read data driven onto AD |
| ad_oe | output | 1 | Output enable for ad_out |
| trdy_n | output | 1 | Target ready, active low |
| devsel_n | output | 1 | Device select, active low |
| stop_n | output | 1 | Stop request, active low |
| load_done | input | 1 | Nonvolatile autoload finished |
| wr_req | output | 1 | Byte write request to the flash buffer |
| wr_addr | output | WIN_BITS | Byte address within the memory window |
| wr_data | output | 8 | Byte to write |
| wr_ready | input | 1 | Flash buffer accepts the byte |

## Verification
The bench uses MEM_BASE = 32'hC000_0000, WIN_BITS = 8 and CFG_WORDS = 8. The narrow window makes in-window and out-of-window memory addresses differ in a single high bit. It also keeps wr_addr short, so the lane and the word bits can be checked in one compare. Eight configuration words give a reference array small enough to track every written byte. Flash waits from zero up to five clocks exercise both the immediate-ready case and a longer hold of wr_req.

// File: rtl/pcit_pkg.sv
`timescale 1ns/1ps
package pcit_pkg;
  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;

  typedef enum logic [2:0] {
    AC_NONE, AC_CFG_RD, AC_CFG_WR, AC_MEM_RD, AC_MEM_WR
  } access_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_DATA, ST_FLASH, ST_ACK, ST_RETRY, ST_SKIP, ST_TURN
  } tstate_t;
endpackage

// File: rtl/pcit_decode.sv
`timescale 1ns/1ps
module pcit_decode
  import pcit_pkg::*;
#(
  parameter logic [31:0] MEM_BASE = 32'hE000_0000,
  parameter int          WIN_BITS = 12
) (
  input  logic [31:0] addr,
  input  logic [3:0]  cmd,
  input  logic        sel,
  input  logic        load_done,
  output access_t     kind,
  output logic        retry
);
  logic cfg_hit;
  logic mem_hit;

  always_comb begin
    cfg_hit = sel && (addr[1:0] == 2'b00);
    mem_hit = (addr[31:WIN_BITS] == MEM_BASE[31:WIN_BITS]);
    kind    = AC_NONE;
    retry   = 1'b0;
    unique case (cmd)
      CMD_CFG_RD: if (cfg_hit) begin kind = AC_CFG_RD; retry = !load_done; end
      CMD_CFG_WR: if (cfg_hit) begin kind = AC_CFG_WR; retry = !load_done; end
      CMD_MEM_RD: if (mem_hit) kind = AC_MEM_RD;
      CMD_MEM_WR: if (mem_hit) kind = AC_MEM_WR;
      default: kind = AC_NONE;
    endcase
  end
endmodule

// File: rtl/pcit_cfg_ram.sv
`timescale 1ns/1ps
module pcit_cfg_ram #(
  parameter int WORDS = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             we,
  input  logic [3:0]       be,
  input  logic [IDX_W-1:0] widx,
  input  logic [31:0]      wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [31:0]      rdata
);
  for (genvar g = 0; g < 4; g++) begin : g_lane
    logic [7:0] mem [WORDS];
    always_ff @(posedge clk) begin
      if (we && be[g]) mem[widx] <= wdata[8*g +: 8];
      rdata[8*g +: 8] <= mem[ridx];
    end
  end
endmodule

// File: rtl/pcit_lane_pick.sv
`timescale 1ns/1ps
module pcit_lane_pick (
  input  logic [3:0]  be_n,
  input  logic [31:0] data,
  output logic        single,
  output logic [1:0]  lane,
  output logic [7:0]  byte_out
);
  logic [2:0] cnt;

  always_comb begin
    cnt  = 3'd0;
    lane = 2'd0;
    for (int i = 0; i < 4; i++) begin
      if (!be_n[i]) begin
        cnt  = cnt + 3'd1;
        lane = i[1:0];
      end
    end
    single   = (cnt == 3'd1);
    byte_out = data[{lane, 3'b000} +: 8];
  end
endmodule

// File: rtl/pcit_target.sv
`timescale 1ns/1ps
module pcit_target
  import pcit_pkg::*;
#(
  parameter logic [31:0] MEM_BASE  = 32'hE000_0000,
  parameter int          WIN_BITS  = 12,
  parameter int          CFG_WORDS = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                frame_n,
  input  logic                irdy_n,
  input  logic                idsel,
  input  logic [31:0]         ad_in,
  input  logic [3:0]          cbe_n,
  output logic [31:0]         ad_out,
  output logic                ad_oe,
  output logic                trdy_n,
  output logic                devsel_n,
  output logic                stop_n,
  input  logic                load_done,
  output logic                wr_req,
  output logic [WIN_BITS-1:0] wr_addr,
  output logic [7:0]          wr_data,
  input  logic                wr_ready
);
  localparam int CFG_IDX_W = (CFG_WORDS > 1) ? $clog2(CFG_WORDS) : 1;

  tstate_t     st;
  logic [31:0] addr_q;
  logic [3:0]  cmd_q;
  logic        sel_q;
  access_t     kind_q;

  access_t     dec_kind;
  logic        dec_retry;
  logic        cfg_we;
  logic [31:0] cfg_rdata;
  logic        be_single;
  logic [1:0]  be_lane;
  logic [7:0]  be_byte;

  pcit_decode #(.MEM_BASE(MEM_BASE), .WIN_BITS(WIN_BITS)) u_dec (
    .addr(addr_q), .cmd(cmd_q), .sel(sel_q), .load_done(load_done),
    .kind(dec_kind), .retry(dec_retry)
  );

  assign cfg_we = (st == ST_DATA) && !irdy_n && (kind_q == AC_CFG_WR);

  pcit_cfg_ram #(.WORDS(CFG_WORDS), .IDX_W(CFG_IDX_W)) u_cfg (
    .clk(clk), .we(cfg_we), .be(~cbe_n),
    .widx(addr_q[2 +: CFG_IDX_W]), .wdata(ad_in),
    .ridx(addr_q[2 +: CFG_IDX_W]), .rdata(cfg_rdata)
  );

  pcit_lane_pick u_lane (
    .be_n(cbe_n), .data(ad_in),
    .single(be_single), .lane(be_lane), .byte_out(be_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      addr_q   <= '0;
      cmd_q    <= '0;
      sel_q    <= 1'b0;
      kind_q   <= AC_NONE;
      ad_out   <= '0;
      ad_oe    <= 1'b0;
      trdy_n   <= 1'b1;
      devsel_n <= 1'b1;
      stop_n   <= 1'b1;
      wr_req   <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (!frame_n) begin
            addr_q <= ad_in;
            cmd_q  <= cbe_n;
            sel_q  <= idsel;
            st     <= ST_ADDR;
          end
        end
        ST_ADDR: begin
          kind_q <= dec_kind;
          if (dec_kind == AC_NONE) begin
            st <= ST_SKIP;
          end else begin
            devsel_n <= 1'b0;
            if (dec_retry) begin
              stop_n <= 1'b0;
              st     <= ST_RETRY;
            end else begin
              st <= ST_DATA;
            end
          end
        end
        ST_DATA: begin
          if (!irdy_n) begin
            unique case (kind_q)
              AC_CFG_RD: begin
                ad_out <= cfg_rdata;
                ad_oe  <= 1'b1;
                trdy_n <= 1'b0;
                st     <= ST_ACK;
              end
              AC_MEM_RD: begin
                ad_out <= '0;
                ad_oe  <= 1'b1;
                trdy_n <= 1'b0;
                st     <= ST_ACK;
              end
              AC_MEM_WR: begin
                if (be_single) begin
                  wr_req  <= 1'b1;
                  wr_data <= be_byte;
                  wr_addr <= {addr_q[WIN_BITS-1:2], be_lane};
                  st      <= ST_FLASH;
                end else begin
                  trdy_n <= 1'b0;
                  st     <= ST_ACK;
                end
              end
              default: begin
                trdy_n <= 1'b0;
                st     <= ST_ACK;
              end
            endcase
          end
        end
        ST_FLASH: begin
          if (wr_ready) begin
            wr_req <= 1'b0;
            trdy_n <= 1'b0;
            st     <= ST_ACK;
          end
        end
        ST_ACK: begin
          if (!irdy_n) begin
            trdy_n   <= 1'b1;
            devsel_n <= 1'b1;
            ad_oe    <= 1'b0;
            st       <= ST_TURN;
          end
        end
        ST_RETRY: begin
          if (frame_n && irdy_n) begin
            stop_n   <= 1'b1;
            devsel_n <= 1'b1;
            st       <= ST_IDLE;
          end
        end
        ST_SKIP: begin
          if (frame_n && irdy_n) st <= ST_IDLE;
        end
        ST_TURN: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pcit_checker.sv
`timescale 1ns/1ps
module pcit_checker #(
  parameter int WIN_BITS = 12
) (
  input logic                clk,
  input logic                rst,
  input logic                frame_n,
  input logic                irdy_n,
  input logic                trdy_n,
  input logic                devsel_n,
  input logic                stop_n,
  input logic                ad_oe,
  input logic                wr_req,
  input logic                wr_ready,
  input logic [WIN_BITS-1:0] wr_addr,
  input logic [7:0]          wr_data
);
  // R2: a falling DEVSEL# follows FRAME# sampled low two edges earlier
  a_r2_devsel_timing: assert property (@(posedge clk) disable iff (rst)
    $fell(devsel_n) |-> !$past(frame_n, 2));

  // R4: Retry never carries TRDY#
  a_r4_stop_no_trdy: assert property (@(posedge clk) disable iff (rst)
    !stop_n |-> trdy_n);

  // R4: STOP# only while the target is selected
  a_r4_stop_devsel: assert property (@(posedge clk) disable iff (rst)
    !stop_n |-> !devsel_n);

  // R6: read data is driven only in a selected, ready data phase
  a_r6_oe_in_data: assert property (@(posedge clk) disable iff (rst)
    ad_oe |-> (!devsel_n && !trdy_n));

  // R7: the request and its payload hold while the buffer is busy
  a_r7_req_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !wr_ready) |=> (wr_req && $stable(wr_data) && $stable(wr_addr)));

  // R8: accepted byte turns into TRDY# one clock later
  a_r8_ready_to_trdy: assert property (@(posedge clk) disable iff (rst)
    (wr_req && wr_ready) |=> (!wr_req && !trdy_n));

  // R11: completed data phase releases the target signals
  a_r11_release: assert property (@(posedge clk) disable iff (rst)
    (!trdy_n && !irdy_n) |=> (trdy_n && devsel_n && !ad_oe));
endmodule

bind pcit_target pcit_checker #(.WIN_BITS(WIN_BITS)) u_chk (
  .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n),
  .trdy_n(trdy_n), .devsel_n(devsel_n), .stop_n(stop_n), .ad_oe(ad_oe),
  .wr_req(wr_req), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/pcit_target_bench.sv
`timescale 1ns/1ps
module pcit_target_bench;
  localparam logic [31:0] BASE = 32'hC000_0000;
  localparam int WB = 8;
  localparam int CW = 8;
  localparam int K_NONE = 0, K_RETRY = 1, K_CFGW = 2, K_CFGR = 3,
                 K_FLASH = 4, K_FLBAD = 5, K_MEMR = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_n = 1'b1, irdy_n = 1'b1, idsel = 1'b0;
  logic [31:0] ad_in = '0;
  logic [3:0] cbe_n = 4'hF;
  logic [31:0] ad_out;
  logic ad_oe, trdy_n, devsel_n, stop_n;
  logic load_done = 1'b0;
  logic wr_req, wr_ready = 1'b0;
  logic [WB-1:0] wr_addr;
  logic [7:0] wr_data;

  int checks = 0, fails = 0;
  bit cmp_on = 0;
  bit done = 0;
  logic exp_trdy = 1, exp_devsel = 1, exp_stop = 1, exp_req = 0, exp_oe = 0;
  string exp_tag = "R1";
  logic [31:0] cfgm [CW];

  always #10 clk = ~clk;

  pcit_target #(.MEM_BASE(BASE), .WIN_BITS(WB), .CFG_WORDS(CW)) u_pcit_target (
    .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .idsel(idsel),
    .ad_in(ad_in), .cbe_n(cbe_n), .ad_out(ad_out), .ad_oe(ad_oe),
    .trdy_n(trdy_n), .devsel_n(devsel_n), .stop_n(stop_n),
    .load_done(load_done), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_ready(wr_ready)
  );

  // per-clock comparison of the control outputs against the model
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      checks++;
      if (trdy_n !== exp_trdy || devsel_n !== exp_devsel || stop_n !== exp_stop ||
          wr_req !== exp_req || ad_oe !== exp_oe) begin
        fails++;
        $display("FAIL %s: trdy,devsel,stop,req,oe = %b%b%b%b%b expected %b%b%b%b%b",
                 exp_tag, trdy_n, devsel_n, stop_n, wr_req, ad_oe,
                 exp_trdy, exp_devsel, exp_stop, exp_req, exp_oe);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic idle_exp;
    exp_trdy = 1; exp_devsel = 1; exp_stop = 1; exp_req = 0; exp_oe = 0;
  endtask

  function automatic int classify(input logic [3:0] cmd, input logic [31:0] a,
                                  input logic sel, input logic [3:0] be);
    bit cfg_ok = sel && (a[1:0] == 2'b00);
    bit mem_ok = (a[31:WB] == BASE[31:WB]);
    int n = 0;
    for (int i = 0; i < 4; i++) if (!be[i]) n++;
    if (cmd == 4'b1011 && cfg_ok) return load_done ? K_CFGW : K_RETRY;
    if (cmd == 4'b1010 && cfg_ok) return load_done ? K_CFGR : K_RETRY;
    if (cmd == 4'b0111 && mem_ok) return (n == 1) ? K_FLASH : K_FLBAD;
    if (cmd == 4'b0110 && mem_ok) return K_MEMR;
    return K_NONE;
  endfunction

  task automatic txn(input logic [3:0] cmd, input logic [31:0] a, input logic sel,
                     input logic [3:0] be, input logic [31:0] d, input int dly,
                     input string tag);
    int kind = classify(cmd, a, sel, be);
    int idx = (a >> 2) % CW;
    int lane = 0;
    logic [31:0] rexp;
    for (int i = 0; i < 4; i++) if (!be[i]) lane = i;
    // address phase
    frame_n = 0; ad_in = a; cbe_n = cmd; idsel = sel; exp_tag = tag;
    tick;
    // single data phase
    frame_n = 1; irdy_n = 0; ad_in = d; cbe_n = be; idsel = 0;
    tick;
    if (kind != K_NONE) exp_devsel = 0;
    if (kind == K_RETRY) exp_stop = 0;
    exp_tag = (kind == K_RETRY) ? "R4" : ((kind == K_NONE) ? "R3" : "R2");
    case (kind)
      K_NONE: begin
        tick; exp_tag = tag; tick;
        irdy_n = 1; tick; tick;
      end
      K_RETRY: begin
        tick; exp_tag = tag;
        irdy_n = 1; tick;
        idle_exp(); exp_tag = "R4"; tick;
      end
      K_CFGW, K_FLBAD: begin
        tick; exp_tag = tag; exp_trdy = 0;
        if (kind == K_CFGW)
          for (int i = 0; i < 4; i++) if (!be[i]) cfgm[idx][8*i +: 8] = d[8*i +: 8];
        tick; irdy_n = 1; idle_exp(); exp_tag = "R11";
        tick; tick;
      end
      K_CFGR, K_MEMR: begin
        tick; exp_tag = tag; exp_trdy = 0; exp_oe = 1;
        rexp = (kind == K_CFGR) ? cfgm[idx] : 32'h0;
        @(negedge clk); #1;
        chk(tag, ad_out, rexp);
        tick; irdy_n = 1; idle_exp(); exp_tag = "R11";
        tick; tick;
      end
      default: begin // K_FLASH
        tick; exp_tag = "R7"; exp_req = 1;
        @(negedge clk); #1;
        chk("R7", {24'h0, wr_data}, {24'h0, d[8*lane +: 8]});
        chk("R7", {{(32-WB){1'b0}}, wr_addr}, {{(32-WB){1'b0}}, a[WB-1:2], lane[1:0]});
        for (int i = 0; i < dly; i++) begin
          tick;
          @(negedge clk); #1;
          chk("R7", {24'h0, wr_data}, {24'h0, d[8*lane +: 8]});
        end
        wr_ready = 1;
        tick; wr_ready = 0; exp_req = 0; exp_trdy = 0; exp_tag = "R8";
        tick; irdy_n = 1; idle_exp(); exp_tag = "R11";
        tick; tick;
      end
    endcase
  endtask

  task automatic finish_run;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < CW; i++) cfgm[i] = '0;
    tick; cmp_on = 1; exp_tag = "R1";
    tick; tick;
    rst = 0;
    tick; tick;
    // R4: configuration cycles before autoload are retried
    txn(4'b1011, 32'h14, 1, 4'h0, 32'hDEAD_BEEF, 0, "R4");
    txn(4'b1010, 32'h14, 1, 4'h0, 32'h0, 0, "R4");
    // R10: memory cycles honoured before autoload
    txn(4'b0111, BASE + 32'h21, 0, 4'b1101, 32'h0011_2233, 2, "R10");
    txn(4'b0110, BASE + 32'h4, 0, 4'h0, 32'h0, 0, "R10");
    load_done = 1; tick;
    // R6: full write and readback
    txn(4'b1011, 32'h14, 1, 4'h0, 32'hA5A5_1234, 0, "R6");
    txn(4'b1010, 32'h14, 1, 4'h0, 32'h0, 0, "R6");
    // R5: a retried write leaves the store untouched
    load_done = 0; tick;
    txn(4'b1011, 32'h14, 1, 4'h0, 32'h0BAD_0BAD, 0, "R5");
    load_done = 1; tick;
    txn(4'b1010, 32'h14, 1, 4'h0, 32'h0, 0, "R5");
    // R6: partial byte enables
    txn(4'b1011, 32'h14, 1, 4'b1010, 32'h7766_5544, 0, "R6");
    txn(4'b1010, 32'h14, 1, 4'h0, 32'h0, 0, "R6");
    txn(4'b1011, 32'h1C, 1, 4'h0, 32'h0102_0304, 0, "R6");
    txn(4'b1011, 32'h00, 1, 4'h0, 32'hFFEE_DDCC, 0, "R6");
    txn(4'b1010, 32'h1C, 1, 4'h0, 32'h0, 0, "R6");
    txn(4'b1010, 32'h00, 1, 4'h0, 32'h0, 0, "R6");
    // R7 / R8: each lane, varied buffer wait
    for (int l = 0; l < 4; l++)
      txn(4'b0111, BASE + 32'(l * 4 + 8), 0, ~(4'b0001 << l), 32'h8899_AABB + 32'(l), l, "R7");
    txn(4'b0111, BASE + 32'hFC, 0, 4'b0111, 32'h5A00_0000, 5, "R8");
    // R9: illegal byte-enable counts
    txn(4'b0111, BASE + 32'h10, 0, 4'hF, 32'h1111_1111, 0, "R9");
    txn(4'b0111, BASE + 32'h10, 0, 4'h0, 32'h2222_2222, 0, "R9");
    txn(4'b0111, BASE + 32'h10, 0, 4'hC, 32'h3333_3333, 0, "R9");
    txn(4'b0111, BASE + 32'h10, 0, 4'h1, 32'h4444_4444, 0, "R9");
    // R10: memory read after autoload
    txn(4'b0110, BASE + 32'h40, 0, 4'h0, 32'h0, 0, "R10");
    // R3: cycles that are not claimed
    txn(4'b1010, 32'h14, 0, 4'h0, 32'h0, 0, "R3");
    txn(4'b1011, 32'h15, 1, 4'h0, 32'h0, 0, "R3");
    txn(4'b0111, BASE ^ 32'h1000_0000, 0, 4'hE, 32'h0, 0, "R3");
    txn(4'b0010, BASE, 0, 4'h0, 32'h0, 0, "R3");
    // R11: back-to-back accesses after release, store checked unchanged
    txn(4'b1010, 32'h14, 1, 4'h0, 32'h0, 0, "R11");
    txn(4'b1010, 32'h1C, 1, 4'h0, 32'h0, 0, "R11");
    tick; tick;
    finish_run();
  end
endmodule